// File: doc/BRIEF.md
# Runtime-Formatted Serial Frame Transmitter

This block turns one character per request into a serial frame on a single output line. Each frame opens with a low start bit and carries 5 to 9 data bits, least significant first. An optional even or odd parity bit follows the data, and one or two high stop bits close the frame. The frame format comes from configuration inputs and is captured together with the character when the request is accepted. A character accepted while the current frame is still being sent waits in a one-deep holding slot.

Bit boundaries come from one of two sources, chosen at run time. In asynchronous mode a one-cycle baud strobe marks every bit boundary. In synchronous mode an external serial clock is brought into the core clock domain through a two-flop synchronizer. A polarity input then selects whether rising or falling serial-clock edges move the line to the next bit. A request handshake feeds the block. A busy level and a one-cycle done pulse report its progress.

Top module: `sfrm_tx`

## Requirements
- R1: Every frame begins with exactly one start bit at 0 on `txd`.
- R2: Data bits follow the start bit, least significant bit first. `cfg_len` codes 0, 1, 2, 3, 4 select 5, 6, 7, 8, 9 data bits, and codes 5 to 7 also select 9 bits.
- R3: `cfg_par` 2'b10 adds an even-parity bit and 2'b11 adds an odd-parity bit. Codes 2'b00 and 2'b01 add no parity bit. The even-parity bit is the XOR of the active data bits only, the odd-parity bit is its inverse, and the parity bit sits between the last data bit and the first stop bit.
- R4: Stop bits are 1. `cfg_stop2`=0 gives one stop bit and `cfg_stop2`=1 gives two.
- R5: With `sync_mode`=0, `txd` changes only at a clock edge where `baud_tick` was 1, so each bit lasts exactly one tick period. `sclk` has no effect in this mode.
- R6: With `sync_mode`=1, `sclk` passes through two flops. `txd` moves to the next bit at the third rising `clk` edge after a change of `sclk` is first sampled. Only falling `sclk` edges advance the line when `clk_pol`=0, and only rising edges when `clk_pol`=1. `baud_tick` has no effect in this mode.
- R7: `in_ready` is 1 only when no character is waiting and the transmitter is either idle or in the final stop bit of its frame. A character is accepted at a clock edge where `in_valid` and `in_ready` are both 1.
- R8: An accepted character starts its start bit at the first bit boundary after the acceptance edge. If a character waits when the final stop bit ends, its start bit follows with no idle time. A character accepted at the same edge as that boundary starts at the next boundary.
- R9: Data and format are sampled at acceptance. Later changes to `in_data`, `cfg_len`, `cfg_par` or `cfg_stop2` do not alter that frame.
- R10: While `busy`=0, `txd` is 1. `busy` is 1 from the edge after acceptance until the final stop bit of the last frame ends.
- R11: `done` is a one-cycle pulse. It rises at the same edge where the final stop bit of a frame ends.
- R12: After reset, `txd`=1, `in_ready`=1, `busy`=0 and `done`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | Bit-boundary strobe in asynchronous mode |
| sync_mode | input | 1 | 1 selects the serial-clock source for bit boundaries |
| clk_pol | input | 1 | Serial-clock edge that advances the line: 0 falling, 1 rising |
| sclk | input | 1 | External serial clock, asynchronous to `clk` |
| in_data | input | 9 | Character to send, right-aligned |
| in_valid | input | 1 | Request to send `in_data` |
| in_ready | output | 1 | Block can accept a character |
| cfg_len | input | 3 | Data-length code |
| cfg_par | input | 2 | Parity code |
| cfg_stop2 | input | 1 | Two stop bits when 1 |
| txd | output | 1 | Serial data line, idles high |
| busy | output | 1 | A frame is waiting or being sent |
| done | output | 1 | One-cycle pulse at the end of each frame |

## Verification
The hardest case to reach is an acceptance that falls on the very edge where the final stop bit ends. At that edge the character must not be taken by the boundary, and it has to wait one full bit. The stimulus reaches this case by running the baud strobe on every cycle and issuing back-to-back requests, so acceptance and boundary coincide. The synchronous path is also hard to cover. There the stimulus toggles `sclk` at a period unrelated to the bit count and injects random `baud_tick` pulses, while asynchronous runs wiggle `sclk` at random. This shows that each mode ignores the other source.

// File: rtl/sfrm_pkg.sv
package sfrm_pkg;

    localparam int DMAX = 9;
    localparam int FMAX = 1 + DMAX + 1 + 2;
    localparam int CW   = $clog2(FMAX + 1);

    typedef enum logic [1:0] {
        PAR_NONE = 2'b00,
        PAR_RSV  = 2'b01,
        PAR_EVEN = 2'b10,
        PAR_ODD  = 2'b11
    } par_e;

    typedef struct packed {
        logic [2:0] len;
        par_e       par;
        logic       stop2;
    } fmt_t;

    typedef struct packed {
        logic [FMAX-1:0] bits;
        logic [CW-1:0]   nbits;
    } frame_t;

    function automatic int unsigned data_count(input logic [2:0] code);
        return (code > 3'd4) ? 32'd9 : 32'(code) + 32'd5;
    endfunction

    function automatic frame_t build_frame(input logic [DMAX-1:0] d, input fmt_t f);
        frame_t      fr;
        int unsigned n;
        logic        p;
        n       = data_count(f.len);
        p       = 1'b0;
        fr.bits = '1;
        fr.bits[0] = 1'b0;
        for (int unsigned i = 0; i < 32'(DMAX); i++) begin
            if (i < n) begin
                fr.bits[1 + i] = d[i];
                p = p ^ d[i];
            end
        end
        if (f.par[1])
            fr.bits[1 + n] = p ^ f.par[0];
        fr.nbits = CW'(32'd1 + n + (f.par[1] ? 32'd1 : 32'd0) + (f.stop2 ? 32'd2 : 32'd1));
        return fr;
    endfunction

endpackage

// File: rtl/sfrm_step_src.sv
module sfrm_step_src #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sync_mode,
    input  logic clk_pol,
    input  logic baud_tick,
    input  logic sclk,
    output logic step
);
    localparam int CHW = SYNC_STAGES + 1;

    logic [CHW-1:0] chain;
    logic           lvl, prev, edge_hit;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[CHW-2:0], sclk};
    end

    assign lvl      = chain[SYNC_STAGES-1];
    assign prev     = chain[SYNC_STAGES];
    assign edge_hit = (lvl != prev) && (lvl == clk_pol);
    assign step     = sync_mode ? edge_hit : baud_tick;

    // R5: in asynchronous mode the strobe alone decides bit boundaries
    p_async_src_r5: assert property (@(posedge clk) disable iff (rst)
        (!sync_mode && !baud_tick) |-> !step);

endmodule

// File: rtl/sfrm_pending.sv
module sfrm_pending
    import sfrm_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            accept,
    input  logic            take,
    input  logic [DMAX-1:0] data,
    input  fmt_t            fmt,
    output logic            pend,
    output frame_t          nxt
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= 1'b0;
            nxt  <= '0;
        end else if (accept) begin
            pend <= 1'b1;
            nxt  <= build_frame(data, fmt);
        end else if (take) begin
            pend <= 1'b0;
        end
    end

    p_no_accept_full_r7: assert property (@(posedge clk) disable iff (rst)
        accept |-> !pend);

    p_take_has_char_r8: assert property (@(posedge clk) disable iff (rst)
        take |-> pend);

    // R9: held character stays fixed until it is taken
    p_hold_stable_r9: assert property (@(posedge clk) disable iff (rst)
        (pend && !$past(accept)) |-> $stable(nxt));

endmodule

// File: rtl/sfrm_ser.sv
module sfrm_ser
    import sfrm_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   step,
    input  logic   pend,
    input  frame_t nxt,
    output logic   take,
    output logic   run,
    output logic   last,
    output logic   txd,
    output logic   done
);
    frame_t        cur;
    logic [CW-1:0] idx;

    assign last = run && (idx == cur.nbits - CW'(1));
    assign take = step && pend && (!run || last);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur  <= '0;
            idx  <= '0;
            run  <= 1'b0;
            txd  <= 1'b1;
            done <= 1'b0;
        end else begin
            done <= step && last;
            if (step) begin
                if (run && !last) begin
                    idx <= idx + CW'(1);
                    txd <= cur.bits[idx + CW'(1)];
                end else if (pend) begin
                    cur <= nxt;
                    idx <= '0;
                    run <= 1'b1;
                    txd <= nxt.bits[0];
                end else begin
                    run <= 1'b0;
                    txd <= 1'b1;
                end
            end
        end
    end

    p_start_low_r1: assert property (@(posedge clk) disable iff (rst)
        take |=> !txd);

    p_stop_high_r4: assert property (@(posedge clk) disable iff (rst)
        last |-> txd);

    p_bit_on_step_r5: assert property (@(posedge clk) disable iff (rst)
        !$stable(txd) |-> $past(step));

    p_idle_high_r10: assert property (@(posedge clk) disable iff (rst)
        !run |-> txd);

    p_done_single_r11: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

endmodule

// File: rtl/sfrm_tx.sv
module sfrm_tx
    import sfrm_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       baud_tick,
    input  logic       sync_mode,
    input  logic       clk_pol,
    input  logic       sclk,
    input  logic [8:0] in_data,
    input  logic       in_valid,
    output logic       in_ready,
    input  logic [2:0] cfg_len,
    input  logic [1:0] cfg_par,
    input  logic       cfg_stop2,
    output logic       txd,
    output logic       busy,
    output logic       done
);
    logic   step, pend, take, run, last, accept;
    frame_t nxt;
    fmt_t   fmt;

    assign fmt      = '{len: cfg_len, par: par_e'(cfg_par), stop2: cfg_stop2};
    assign in_ready = !pend && (!run || last);
    assign accept   = in_valid && in_ready;
    assign busy     = run || pend;

    sfrm_step_src #(.SYNC_STAGES(SYNC_STAGES)) u_step (
        .clk(clk), .rst(rst), .sync_mode(sync_mode), .clk_pol(clk_pol),
        .baud_tick(baud_tick), .sclk(sclk), .step(step)
    );

    sfrm_pending u_hold (
        .clk(clk), .rst(rst), .accept(accept), .take(take),
        .data(in_data), .fmt(fmt), .pend(pend), .nxt(nxt)
    );

    sfrm_ser u_ser (
        .clk(clk), .rst(rst), .step(step), .pend(pend), .nxt(nxt),
        .take(take), .run(run), .last(last), .txd(txd), .done(done)
    );

    p_accept_busy_r10: assert property (@(posedge clk) disable iff (rst)
        accept |=> busy);

    p_done_idle_r11: assert property (@(posedge clk) disable iff (rst)
        (done && !busy) |-> txd);

endmodule

// File: tb/test_sfrm_tx.sv
`timescale 1ns/1ps
module test_sfrm_tx;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       baud_tick = 1'b0, sync_mode = 1'b0, clk_pol = 1'b0, sclk = 1'b0;
    logic [8:0] in_data = '0;
    logic       in_valid = 1'b0;
    logic [2:0] cfg_len = '0;
    logic [1:0] cfg_par = '0;
    logic       cfg_stop2 = 1'b0;
    logic       in_ready, txd, busy, done;

    always #10 clk = ~clk;

    sfrm_tx i_sfrm_tx (
        .clk(clk), .rst(rst), .baud_tick(baud_tick), .sync_mode(sync_mode),
        .clk_pol(clk_pol), .sclk(sclk), .in_data(in_data), .in_valid(in_valid),
        .in_ready(in_ready), .cfg_len(cfg_len), .cfg_par(cfg_par),
        .cfg_stop2(cfg_stop2), .txd(txd), .busy(busy), .done(done)
    );

    int    total = 0, bad = 0;
    string tag = "R12";
    int    cur[$];
    int    pq[$];
    int    hist[$];
    bit    m_pend = 0, m_txd = 1, m_done = 0;
    int    div = 4, tcnt = 0, shalf = 3, scnt = 0;
    bit    tick_noise = 0, sclk_noise = 0;

    function automatic bit m_ready();
        return !m_pend && (cur.size() <= 1);
    endfunction

    function automatic bit m_busy();
        return (cur.size() > 0) || m_pend;
    endfunction

    task automatic chk(input string what, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s act=%b exp=%b t=%0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        cur.delete(); pq.delete(); hist = '{0, 0, 0};
        m_pend = 0; m_txd = 1; m_done = 0;
    endtask

    task automatic fill_pending();
        int n, p;
        n = (cfg_len > 4) ? 9 : int'(cfg_len) + 5;
        pq.delete();
        pq.push_back(0);
        p = 0;
        for (int i = 0; i < n; i++) begin
            pq.push_back(int'(in_data[i]));
            p = p ^ int'(in_data[i]);
        end
        if (cfg_par == 2'b10) pq.push_back(p);
        if (cfg_par == 2'b11) pq.push_back(1 - p);
        pq.push_back(1);
        if (cfg_stop2) pq.push_back(1);
    endtask

    task automatic model_edge();
        bit st, acc;
        acc = in_valid && m_ready();
        if (sync_mode) st = (hist[1] != hist[2]) && (hist[1] == int'(clk_pol));
        else           st = baud_tick;
        hist.push_front(int'(sclk));
        void'(hist.pop_back());
        m_done = 0;
        if (st) begin
            if (cur.size() > 1) begin
                void'(cur.pop_front());
                m_txd = cur[0][0];
            end else begin
                m_done = (cur.size() == 1);
                cur.delete();
                if (m_pend) begin
                    cur = pq;
                    m_pend = 0;
                    m_txd = cur[0][0];
                end else begin
                    m_txd = 1;
                end
            end
        end
        if (acc) begin
            fill_pending();
            m_pend = 1;
        end
    endtask

    task automatic cyc();
        if (!sync_mode) baud_tick = (tcnt == 0);
        else            baud_tick = tick_noise ? 1'($urandom % 2) : 1'b0;
        tcnt = (tcnt + 1 >= div) ? 0 : tcnt + 1;
        if (sync_mode) begin
            scnt++;
            if (scnt >= shalf) begin sclk = ~sclk; scnt = 0; end
        end else if (sclk_noise) begin
            sclk = 1'($urandom % 2);
        end
        @(posedge clk);
        @(negedge clk);
        if (rst) model_reset();
        else begin
            model_edge();
            chk("txd", txd, m_txd);
            chk("ready R7", in_ready, m_ready());
            chk("busy R10", busy, m_busy());
            chk("done R11", done, m_done);
        end
    endtask

    task automatic send(input logic [8:0] d, input logic [2:0] l,
                        input logic [1:0] p, input logic s2);
        bit acc;
        int guard;
        guard = 0;
        in_valid = 1; in_data = d; cfg_len = l; cfg_par = p; cfg_stop2 = s2;
        do begin
            acc = in_valid && m_ready();
            cyc();
            guard++;
        end while (!acc && guard < 4000);
        in_valid = 0;
        // R9: scramble inputs once the character is taken
        in_data = 9'($urandom); cfg_len = 3'($urandom);
        cfg_par = 2'($urandom); cfg_stop2 = 1'($urandom);
    endtask

    task automatic wait_idle();
        int guard;
        guard = 0;
        while (m_busy() && guard < 4000) begin cyc(); guard++; end
        repeat (3) cyc();
    endtask

    initial begin
        #3_000_000;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) cyc();
        rst = 0;
        @(negedge clk);
        tag = "R12";
        chk("reset txd R12", txd, 1'b1);
        chk("reset ready R12", in_ready, 1'b1);
        chk("reset busy R12", busy, 1'b0);
        chk("reset done R12", done, 1'b0);
        repeat (2) cyc();

        tag = "R2";  // also R1: start bit precedes each length
        for (int l = 0; l < 8; l++) begin
            send(9'(9'h1A5 ^ (l * 37)), 3'(l), 2'b00, 1'b0);
            wait_idle();
        end

        tag = "R3";
        send(9'h0FF, 3'd3, 2'b10, 1'b0); wait_idle();
        send(9'h0FE, 3'd3, 2'b10, 1'b0); wait_idle();
        send(9'h155, 3'd4, 2'b11, 1'b0); wait_idle();
        send(9'h1E0, 3'd0, 2'b10, 1'b0); wait_idle();
        send(9'h0A3, 3'd2, 2'b01, 1'b0); wait_idle();

        tag = "R4";
        send(9'h133, 3'd4, 2'b11, 1'b1); wait_idle();
        send(9'h00C, 3'd1, 2'b00, 1'b1); wait_idle();

        tag = "R8";
        send(9'h111, 3'd4, 2'b10, 1'b1);
        send(9'h0AA, 3'd0, 2'b11, 1'b0);
        send(9'h1C7, 3'd2, 2'b00, 1'b1);
        wait_idle();
        div = 1;
        send(9'h05A, 3'd0, 2'b00, 1'b0);
        send(9'h1FF, 3'd4, 2'b11, 1'b0);
        send(9'h000, 3'd3, 2'b10, 1'b1);
        wait_idle();

        tag = "R9";
        div = 5;
        send(9'h0C3, 3'd3, 2'b10, 1'b0);
        send(9'h13C, 3'd4, 2'b11, 1'b1);
        wait_idle();

        tag = "R5";
        div = 3; sclk_noise = 1;
        send(9'h099, 3'd3, 2'b11, 1'b1);
        send(9'h166, 3'd4, 2'b00, 1'b0);
        wait_idle();
        sclk_noise = 0;

        tag = "R6";
        sclk = 0; scnt = 0;
        sync_mode = 1; tick_noise = 1; clk_pol = 0; shalf = 3;
        repeat (4) cyc();
        send(9'h1B4, 3'd4, 2'b10, 1'b0);
        send(9'h02D, 3'd1, 2'b11, 1'b1);
        wait_idle();
        clk_pol = 1; shalf = 2;
        repeat (4) cyc();
        send(9'h0E7, 3'd3, 2'b00, 1'b1);
        send(9'h171, 3'd4, 2'b11, 1'b0);
        wait_idle();
        sync_mode = 0; tick_noise = 0; div = 4;
        repeat (4) cyc();

        tag = "R11";
        send(9'h03C, 3'd2, 2'b10, 1'b0);
        wait_idle();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule